// File: doc/BRIEF.md
# Masked content addressable memory

This block stores a small array of words, each with its own valid flag, and finds them by value instead of by position. A search value sits in an argument register and a per-bit mask sits in a key register. A one-cycle search strobe compares every stored word with the argument at once. Only the bit positions whose key bit is 1 take part in the compare. The outcome is held in a match vector with one bit per word, together with an any-match flag.

After a search, the matching words are presented one at a time on a readout port. Each readout gives the word's index and its contents. The lowest matching index comes first. A step input moves the readout to the next higher match. When no match is left, a done flag is raised.

A write port loads or invalidates a word by index. It may be used in any cycle, including the cycle of a search.

Top module: `keyed_cam`

## Requirements
- R1: After synchronous reset, match_vec, any_match, rd_valid, rd_done, rd_idx and rd_data are all 0, and every word is invalid, so a search with an all-zero key finds nothing.
- R2: One cycle after a search strobe, match_vec bit i is 1 exactly when word i is valid and equals the argument register on every compared position; all words are compared in that single search.
- R3: A bit position takes part in the compare only where the key register bit is 1; with an all-zero key every valid word matches.
- R4: A word written with wr_valid=0 is invalid and never sets its match bit, whatever the argument and key.
- R5: any_match is the OR of match_vec and changes in the same cycle as match_vec.
- R6: match_vec and any_match keep their values in every cycle without a search strobe.
- R7: One cycle after a search with at least one match, rd_valid is 1, rd_idx is the lowest matching index and rd_data is that word's contents; while rd_valid is 0, rd_idx and rd_data read 0.
- R8: A rd_next pulse while rd_valid is 1 moves the readout, one cycle later, to the next higher matching index. When none is left, rd_valid drops and rd_done rises. A search with no match raises rd_done at once.
- R9: A write in the same cycle as a search does not affect that search, which compares the old contents; the new contents take part in later searches.
- R10: Argument or key loads in the same cycle as a search take effect only for later searches.
- R11: rd_next is ignored while rd_valid is 0. A search in the same cycle as rd_next wins and restarts the readout from the new results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_load | input | 1 | Load the argument register |
| arg_value | input | WIDTH | New argument value |
| key_load | input | 1 | Load the key (mask) register |
| key_value | input | WIDTH | New key value; 1 = compare this bit |
| search | input | 1 | Search strobe |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDXW | Word index to write |
| wr_data | input | WIDTH | Data to store |
| wr_valid | input | 1 | Valid flag stored with the word |
| rd_next | input | 1 | Step the readout to the next match |
| match_vec | output | WORDS | One match bit per word from the last search |
| any_match | output | 1 | At least one word matched in the last search |
| rd_valid | output | 1 | Readout port holds a matching word |
| rd_idx | output | IDXW | Index of the word on the readout port |
| rd_data | output | WIDTH | Contents of that word |
| rd_done | output | 1 | The last search has no further matches to read |

## Verification
The bench focuses on four hazards. Masked compares with partial and all-zero keys would catch a design that compares every bit. Invalidated words with data that matches would catch a design that forgets the valid flag. A write or an argument load in the same cycle as a search would expose a design that lets fresh contents race into the compare. Readouts stepped past the last match, and searches issued in the middle of a readout, would show a design that skips indices, repeats them, or keeps stale cursor state when a new search arrives.

// File: rtl/keyed_cam_pkg.sv
package keyed_cam_pkg;
  localparam int KC_WORDS_DEF = 8;
  localparam int KC_WIDTH_DEF = 8;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_BUSY = 2'd1,
    SCAN_DONE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/kc_array.sv
module kc_array #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] arg,
  input  logic [WIDTH-1:0] key,
  input  logic [IDXW-1:0]  pick_idx,
  output logic [WORDS-1:0] hits,
  output logic [WIDTH-1:0] pick_word
);
  logic [WIDTH-1:0] mem [WORDS];
  logic [WORDS-1:0] live;

  // data array: no reset, one write port
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < WORDS))
      mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      live <= '0;
    else if (wr_en && (int'(wr_idx) < WORDS))
      live[wr_idx] <= wr_valid;
  end

  // parallel masked compare, one comparator per word
  for (genvar g = 0; g < WORDS; g++) begin : g_cmp
    assign hits[g] = live[g] && (((mem[g] ^ arg) & key) == '0);
  end

  assign pick_word = mem[pick_idx];
endmodule

// File: rtl/kc_scan.sv
module kc_scan
  import keyed_cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             search,
  input  logic             step,
  input  logic [WORDS-1:0] hits,
  input  logic [WIDTH-1:0] pick_word,
  output logic [IDXW-1:0]  pick_idx,
  output logic [WORDS-1:0] match_vec,
  output logic             any_match,
  output logic             rd_valid,
  output logic [IDXW-1:0]  rd_idx,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_done
);
  scan_state_e      state;
  logic [WORDS-1:0] pending;
  logic [WORDS-1:0] src;
  logic             advance;
  logic             found;

  assign advance = search || (step && (state == SCAN_BUSY));

  always_comb begin
    src = pending;
    src[rd_idx] = 1'b0;
    if (search) src = hits;
  end

  // lowest set bit of src
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (src[i]) begin
        found    = 1'b1;
        pick_idx = IDXW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SCAN_IDLE;
      pending   <= '0;
      match_vec <= '0;
      any_match <= 1'b0;
      rd_idx    <= '0;
      rd_data   <= '0;
    end else begin
      if (search) begin
        match_vec <= hits;
        any_match <= |hits;
      end
      if (advance) begin
        pending <= src;
        state   <= found ? SCAN_BUSY : SCAN_DONE;
        rd_idx  <= found ? pick_idx : '0;
        rd_data <= found ? pick_word : '0;
      end
    end
  end

  assign rd_valid = (state == SCAN_BUSY);
  assign rd_done  = (state == SCAN_DONE);
endmodule

// File: rtl/keyed_cam.sv
module keyed_cam
  import keyed_cam_pkg::*;
#(
  parameter int WORDS = KC_WORDS_DEF,
  parameter int WIDTH = KC_WIDTH_DEF,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arg_load,
  input  logic [WIDTH-1:0] arg_value,
  input  logic             key_load,
  input  logic [WIDTH-1:0] key_value,
  input  logic             search,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  input  logic             rd_next,
  output logic [WORDS-1:0] match_vec,
  output logic             any_match,
  output logic             rd_valid,
  output logic [IDXW-1:0]  rd_idx,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_done
);
  logic [WIDTH-1:0] arg_q;
  logic [WIDTH-1:0] key_q;
  logic [WORDS-1:0] hits;
  logic [IDXW-1:0]  pick_idx;
  logic [WIDTH-1:0] pick_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      arg_q <= '0;
      key_q <= '0;
    end else begin
      if (arg_load) arg_q <= arg_value;
      if (key_load) key_q <= key_value;
    end
  end

  kc_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .arg       (arg_q),
    .key       (key_q),
    .pick_idx  (pick_idx),
    .hits      (hits),
    .pick_word (pick_word)
  );

  kc_scan #(.WORDS(WORDS), .WIDTH(WIDTH)) u_scan (
    .clk       (clk),
    .rst       (rst),
    .search    (search),
    .step      (rd_next),
    .hits      (hits),
    .pick_word (pick_word),
    .pick_idx  (pick_idx),
    .match_vec (match_vec),
    .any_match (any_match),
    .rd_valid  (rd_valid),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .rd_done   (rd_done)
  );
endmodule

// File: rtl/keyed_cam_chk.sv
module keyed_cam_chk #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             search,
  input logic             rd_next,
  input logic [WORDS-1:0] match_vec,
  input logic             any_match,
  input logic             rd_valid,
  input logic [IDXW-1:0]  rd_idx,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_done
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (match_vec == '0 && !any_match && !rd_valid && !rd_done && rd_idx == '0 && rd_data == '0));

  // R5
  any_or_chk: assert property (@(posedge clk) disable iff (rst)
    any_match == (match_vec != '0));

  // R6
  match_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!search && !$past(rst)) |=> ($stable(match_vec) && $stable(any_match)));

  // R7
  cursor_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> match_vec[rd_idx]);

  // R8
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_done));

  // R8
  step_ascends_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_next && !search) |=> (!rd_valid || rd_idx > $past(rd_idx)));

  // R11
  idle_step_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && !search) |=> ($stable(rd_idx) && $stable(rd_done) && !rd_valid));
endmodule

bind keyed_cam keyed_cam_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .search    (search),
  .rd_next   (rd_next),
  .match_vec (match_vec),
  .any_match (any_match),
  .rd_valid  (rd_valid),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .rd_done   (rd_done)
);

// File: tb/keyed_cam_bench.sv
`timescale 1ns/1ps
module keyed_cam_bench;
  localparam int M  = 8;
  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arg_load = 0, key_load = 0, search = 0, wr_en = 0, wr_valid = 0, rd_next = 0;
  logic [W-1:0]  arg_value = '0, key_value = '0, wr_data = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [M-1:0]  match_vec;
  logic          any_match, rd_valid, rd_done;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  rd_data;

  always #2.5 clk = ~clk;

  keyed_cam #(.WORDS(M), .WIDTH(W)) u_keyed_cam (
    .clk(clk), .rst(rst), .arg_load(arg_load), .arg_value(arg_value),
    .key_load(key_load), .key_value(key_value), .search(search),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_next(rd_next), .match_vec(match_vec), .any_match(any_match),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .rd_done(rd_done)
  );

  // behavioural reference state
  logic [W-1:0] m_mem [M];
  bit           m_live [M];
  logic [W-1:0] m_arg, m_key;
  bit           m_hit [M];
  bit           m_pend [M];
  bit           m_any, m_valid, m_done;
  int           m_idx;
  logic [W-1:0] m_data;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    finished = 0;

  function automatic int first_pending();
    for (int i = 0; i < M; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  task automatic settle_cursor();
    int f;
    f = first_pending();
    m_valid = (f >= 0);
    m_done  = (f < 0);
    m_idx   = (f >= 0) ? f : 0;
    m_data  = (f >= 0) ? m_mem[f] : '0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < M; i++) begin m_live[i] = 0; m_hit[i] = 0; m_pend[i] = 0; end
      m_arg = '0; m_key = '0; m_any = 0; m_valid = 0; m_done = 0; m_idx = 0; m_data = '0;
    end else begin
      if (search) begin
        m_any = 0;
        for (int i = 0; i < M; i++) begin
          m_hit[i]  = m_live[i] && (((m_mem[i] ^ m_arg) & m_key) == '0);
          m_pend[i] = m_hit[i];
          if (m_hit[i]) m_any = 1;
        end
        settle_cursor();
      end else if (rd_next && m_valid) begin
        m_pend[m_idx] = 0;
        settle_cursor();
      end
      if (wr_en) begin m_mem[wr_idx] = wr_data; m_live[wr_idx] = wr_valid; end
      if (arg_load) m_arg = arg_value;
      if (key_load) m_key = key_value;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [M-1:0] ev;
    for (int i = 0; i < M; i++) ev[i] = m_hit[i];
    chk("match_vec", 32'(match_vec), 32'(ev));
    chk("any_match", 32'(any_match), 32'(m_any));
    chk("rd_valid",  32'(rd_valid),  32'(m_valid));
    chk("rd_done",   32'(rd_done),   32'(m_done));
    chk("rd_idx",    32'(rd_idx),    32'(m_idx));
    chk("rd_data",   32'(rd_data),   32'(m_data));
  endtask

  // one clock: inputs set before the call are applied at the next edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
    arg_load = 0; key_load = 0; search = 0; wr_en = 0; rd_next = 0;
  endtask

  task automatic wr(int idx, logic [W-1:0] d, bit v);
    wr_en = 1; wr_idx = IW'(idx); wr_data = d; wr_valid = v;
    cyc();
  endtask

  task automatic setup(logic [W-1:0] a, logic [W-1:0] k);
    arg_load = 1; arg_value = a; key_load = 1; key_value = k;
    cyc();
  endtask

  task automatic find();
    search = 1;
    cyc();
  endtask

  task automatic drain();
    for (int n = 0; n < M + 2; n++) begin
      rd_next = 1;
      cyc();
    end
  endtask

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst = 0;
    tag = "R1"; cyc();
    setup('0, '0); find(); cyc();

    tag = "R4";
    wr(0, 8'h3C, 1); wr(1, 8'hA5, 1); wr(2, 8'h3C, 1); wr(3, 8'h5A, 1);
    wr(4, 8'hFF, 1); wr(5, 8'h3D, 1); wr(6, 8'h3C, 0); wr(7, 8'h00, 1);

    tag = "R2"; setup(8'h3C, 8'hFF); find();
    tag = "R7"; cyc();
    tag = "R8"; drain();
    tag = "R11"; rd_next = 1; cyc(); cyc();

    tag = "R3"; setup(8'h30, 8'hF0); find(); drain();
    tag = "R3"; setup(8'h00, 8'h00); find(); drain();

    tag = "R5"; setup(8'h77, 8'hFF); find(); cyc();

    tag = "R10"; setup(8'hA5, 8'hFF);
    arg_load = 1; arg_value = 8'h5A; search = 1; cyc();
    find(); drain();

    tag = "R9";
    setup(8'h3C, 8'hFF);
    wr_en = 1; wr_idx = 3'd3; wr_data = 8'h3C; wr_valid = 1; search = 1; cyc();
    drain(); find(); cyc();

    tag = "R11";
    rd_next = 1; cyc();
    arg_load = 1; arg_value = 8'hFF; cyc();
    search = 1; rd_next = 1; cyc(); cyc();

    tag = "R6"; cyc(); cyc(); cyc();

    tag = "R4"; setup(8'h3C, 8'hFF); wr(0, 8'h3C, 0); find(); drain();
    wr(6, 8'h3C, 1); find(); drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule